// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block is a passive observer on the command bus of a four-bank synchronous DRAM. On every clock it decodes the command pins and keeps a record for each bank. The record holds whether the bank has an open row, how long ago it was activated or closed, and when its last write data beat went by. The block does not drive the bus. It raises one pulse per broken rule, which a testbench or an on-chip debug path can count or trap.

The monitor follows one column burst at a time, because the data bus carries only one. That is enough to place the last write beat and to find where an auto-precharge begins. A burst ends after `BURST_LEN` beats, or earlier when a burst stop, a new read or write, or a precharge of its bank cuts it short. All timing limits are parameters counted in clock cycles. When the previous clock saw clock-enable low, the cycle is not a command cycle and every counter holds its value. `BURST_LEN` must be at least 2.

Top module: `sdram_timing_mon`

## Requirements
- R1: During reset and in the first cycle after it, `viol` and `err` are zero and all banks are idle. The counters start saturated, so no minimum-time rule applies to the first commands.
- R2: A read or write to a bank less than `T_RCD` cycles after that bank's activate sets `viol[0]`. Commands are decoded with `cs_n` low from {`ras_n`,`cas_n`,`we_n`}: 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge (`a10` high = all banks), 001 refresh, 000 mode register set, 111 no operation.
- R3: An activate less than `T_RP` cycles after that bank was closed sets `viol[1]`. The bank is closed by a precharge, or by the end of a read burst issued with auto-precharge (`a10` high on the read).
- R4: An activate less than `T_RRD` cycles after any earlier activate sets `viol[2]`.
- R5: A precharge of an open bank less than `T_RAS_MIN` cycles after its activate sets `viol[3]`.
- R6: A bank whose row is still open exactly `T_RAS_MAX` cycles after its activate sets `viol[4]` for one cycle. A precharge at that exact cycle is legal.
- R7: A precharge of an open bank less than `T_RDL` cycles after its last write data beat sets `viol[5]`. A write puts beats in its own cycle and the next `BURST_LEN-1` cycles, unless the burst is cut short earlier.
- R8: After a write with auto-precharge, an activate to that bank less than `T_RDL+T_RP` cycles after the burst's last beat sets `viol[6]`.
- R9: A read or write issued while a burst with auto-precharge is still running sets `viol[7]`, whichever bank it targets. Once that burst has ended, other banks can be accessed freely.
- R10: A read or write to an idle bank, or an activate to an open bank, sets `viol[8]`. An illegal activate leaves that bank's state unchanged.
- R11: A refresh or mode-register command while any bank is open sets `viol[9]`.
- R12: When `cke` was low at the previous clock edge, the current cycle's command is ignored, all counters hold, and `viol` is zero after that edge.
- R13: Each `viol` bit is high for the one cycle after the clock edge that sampled the offending command. `err` is high exactly when some `viol` bit is high. A burst stop is legal for any burst length and shortens the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NBANK) | Bank address |
| a10 | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| viol | output | 10 | One-cycle pulse per broken rule, bit order as in R2 to R11 |
| err | output | 1 | Any rule broken in the last command cycle |

## Verification
The activate-to-column property assumes the stimulus never activates a bank that is already open. An illegal activate leaves the counter of the earlier activate running, so the flag would not fire. Every scenario therefore closes a bank before it activates it again. The back-to-back properties rely on `BURST_LEN`, `T_RCD` and `T_RRD` all being at least 2, and they are generated only under that condition. The clock-enable property assumes that clock enable is high out of reset. The bench keeps it high outside the single stall scenario.

// File: rtl/sdtm_pkg.sv
package sdtm_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef struct packed {
        cmd_e op;
        logic ap;
    } cmd_t;

    localparam int RL_RCD    = 0;
    localparam int RL_RP     = 1;
    localparam int RL_RRD    = 2;
    localparam int RL_RASMIN = 3;
    localparam int RL_RASMAX = 4;
    localparam int RL_RDL    = 5;
    localparam int RL_DAL    = 6;
    localparam int RL_AP     = 7;
    localparam int RL_STATE  = 8;
    localparam int RL_IDLE   = 9;
    localparam int NRULE     = 10;

    function automatic cmd_e pins_to_cmd(input logic ras_n, input logic cas_n,
                                         input logic we_n);
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b110:  return CMD_BST;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdtm_decode.sv
module sdtm_decode import sdtm_pkg::*; #(
    parameter int NBANK = 4,
    localparam int BA_W = $clog2(NBANK)
) (
    input  logic             adv,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic             a10,
    output cmd_t             cmd,
    output logic [NBANK-1:0] sel
);
    always_comb begin
        cmd.op = CMD_NOP;
        cmd.ap = a10;
        if (adv && !cs_n) begin
            cmd.op = pins_to_cmd(ras_n, cas_n, we_n);
        end
        if (cmd.op == CMD_PRE && a10) begin
            sel = '1;
        end else begin
            sel = NBANK'(1) << ba;
        end
    end
endmodule

// File: rtl/sdtm_burst.sv
module sdtm_burst #(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    localparam int BA_W = $clog2(NBANK),
    localparam int RW   = $clog2(BURST_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            col,
    input  logic            col_wr,
    input  logic            col_ap,
    input  logic [BA_W-1:0] col_ba,
    input  logic            bst,
    input  logic            pre,
    input  logic            pre_all,
    output logic            running,
    output logic            run_ap,
    output logic            wbeat,
    output logic [BA_W-1:0] wbeat_ba,
    output logic            close,
    output logic [BA_W-1:0] close_ba,
    output logic            close_wr
);
    localparam logic [RW-1:0] REM_START = RW'(BURST_LEN - 1);

    logic [RW-1:0]   rem;
    logic [BA_W-1:0] cur_ba;
    logic            cur_wr;
    logic            cur_ap;
    logic            pre_hit;
    logic            term;
    logic            cont;

    always_comb begin
        running  = (rem != '0);
        run_ap   = running && cur_ap;
        pre_hit  = pre && (pre_all || col_ba == cur_ba);
        term     = running && (col || bst || pre_hit);
        cont     = running && !term;
        wbeat    = (col && col_wr) || (cont && cur_wr);
        wbeat_ba = col ? col_ba : cur_ba;
        close    = cur_ap && ((cont && rem == RW'(1)) || term);
        close_ba = cur_ba;
        close_wr = cur_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            cur_ba <= '0;
            cur_wr <= 1'b0;
            cur_ap <= 1'b0;
        end else if (adv) begin
            if (col) begin
                rem    <= REM_START;
                cur_ba <= col_ba;
                cur_wr <= col_wr;
                cur_ap <= col_ap;
            end else if (term) begin
                rem <= '0;
            end else if (running) begin
                rem <= rem - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdtm_bank.sv
module sdtm_bank import sdtm_pkg::*; #(
    parameter int CNT_W     = 8,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 100,
    parameter int T_RDL     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             ev_act,
    input  logic             ev_pre,
    input  logic             ev_col,
    input  logic             ev_wbeat,
    input  logic             ev_close,
    input  logic             close_wr,
    output logic             active,
    output logic [NRULE-1:0] flag
);
    localparam logic [CNT_W-1:0] L_RCD    = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] L_RP     = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] L_RASMIN = CNT_W'(T_RAS_MIN);
    localparam logic [CNT_W-1:0] L_RASMAX = CNT_W'(T_RAS_MAX);
    localparam logic [CNT_W-1:0] L_RDL    = CNT_W'(T_RDL);
    localparam logic [CNT_W-1:0] L_DAL    = CNT_W'(T_RDL + T_RP);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic             ap_wr;
    logic [CNT_W-1:0] act_cnt;
    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] wd_cnt;

    always_comb begin
        flag            = '0;
        flag[RL_RCD]    = ev_col && active && (act_cnt < L_RCD);
        flag[RL_RP]     = ev_act && !active && !ap_wr && (pre_cnt < L_RP);
        flag[RL_DAL]    = ev_act && !active && ap_wr && (wd_cnt < L_DAL);
        flag[RL_RASMIN] = ev_pre && active && (act_cnt < L_RASMIN);
        flag[RL_RDL]    = ev_pre && active && (wd_cnt < L_RDL);
        flag[RL_RASMAX] = active && !ev_pre && !ev_close && (act_cnt == L_RASMAX);
        flag[RL_STATE]  = (ev_col && !active) || (ev_act && active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ap_wr   <= 1'b0;
            act_cnt <= '1;
            pre_cnt <= '1;
            wd_cnt  <= '1;
        end else if (adv) begin
            act_cnt <= (act_cnt == '1) ? act_cnt : act_cnt + 1'b1;
            pre_cnt <= (pre_cnt == '1) ? pre_cnt : pre_cnt + 1'b1;
            wd_cnt  <= (wd_cnt  == '1) ? wd_cnt  : wd_cnt  + 1'b1;
            if (ev_wbeat) begin
                wd_cnt <= ONE;
            end
            if (ev_pre && active) begin
                active  <= 1'b0;
                ap_wr   <= 1'b0;
                pre_cnt <= ONE;
            end else if (ev_close) begin
                active <= 1'b0;
                ap_wr  <= close_wr;
                if (!close_wr) begin
                    pre_cnt <= ONE;
                end
            end else if (ev_act && !active) begin
                active  <= 1'b1;
                ap_wr   <= 1'b0;
                act_cnt <= ONE;
            end
        end
    end
endmodule

// File: rtl/sdram_timing_mon.sv
module sdram_timing_mon import sdtm_pkg::*; #(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 13334,
    parameter int T_RDL     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cke,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [$clog2(NBANK)-1:0] ba,
    input  logic                     a10,
    output logic [NRULE-1:0]         viol,
    output logic                     err
);
    localparam int BA_W  = $clog2(NBANK);
    localparam int T_TOP = max_int(max_int(T_RAS_MAX, T_RDL + T_RP),
                                   max_int(T_RRD, T_RCD));
    localparam int CNT_W = $clog2(T_TOP + 2);
    localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD);

    logic             cke_q;
    logic             adv;
    cmd_t             cmd;
    logic [NBANK-1:0] sel;
    logic             col;
    logic             running;
    logic             run_ap;
    logic             wbeat;
    logic [BA_W-1:0]  wbeat_ba;
    logic             close;
    logic [BA_W-1:0]  close_ba;
    logic             close_wr;
    logic [NBANK-1:0] wsel;
    logic [NBANK-1:0] csel;
    logic [NBANK-1:0] active;
    logic [NRULE-1:0] bflag [NBANK];
    logic [CNT_W-1:0] rrd_cnt;
    logic [NRULE-1:0] viol_d;

    assign adv = cke_q;
    assign col = (cmd.op == CMD_RD) || (cmd.op == CMD_WR);

    sdtm_decode #(.NBANK(NBANK)) u_dec (
        .adv   (adv),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .a10   (a10),
        .cmd   (cmd),
        .sel   (sel)
    );

    sdtm_burst #(.NBANK(NBANK), .BURST_LEN(BURST_LEN)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .col      (col),
        .col_wr   (cmd.op == CMD_WR),
        .col_ap   (cmd.ap),
        .col_ba   (ba),
        .bst      (cmd.op == CMD_BST),
        .pre      (cmd.op == CMD_PRE),
        .pre_all  (cmd.ap),
        .running  (running),
        .run_ap   (run_ap),
        .wbeat    (wbeat),
        .wbeat_ba (wbeat_ba),
        .close    (close),
        .close_ba (close_ba),
        .close_wr (close_wr)
    );

    assign wsel = wbeat ? (NBANK'(1) << wbeat_ba) : '0;
    assign csel = close ? (NBANK'(1) << close_ba) : '0;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdtm_bank #(
            .CNT_W     (CNT_W),
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RAS_MIN (T_RAS_MIN),
            .T_RAS_MAX (T_RAS_MAX),
            .T_RDL     (T_RDL)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .adv      (adv),
            .ev_act   ((cmd.op == CMD_ACT) && sel[g]),
            .ev_pre   ((cmd.op == CMD_PRE) && sel[g]),
            .ev_col   (col && sel[g]),
            .ev_wbeat (wsel[g]),
            .ev_close (csel[g]),
            .close_wr (close_wr),
            .active   (active[g]),
            .flag     (bflag[g])
        );
    end

    always_comb begin
        viol_d = '0;
        for (int b = 0; b < NBANK; b++) begin
            viol_d = viol_d | bflag[b];
        end
        viol_d[RL_RRD]  = (cmd.op == CMD_ACT) && (rrd_cnt < L_RRD);
        viol_d[RL_AP]   = col && run_ap;
        viol_d[RL_IDLE] = ((cmd.op == CMD_REF) || (cmd.op == CMD_MRS)) && (active != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q   <= 1'b1;
            rrd_cnt <= '1;
            viol    <= '0;
        end else begin
            cke_q <= cke;
            viol  <= adv ? viol_d : '0;
            if (adv) begin
                if (cmd.op == CMD_ACT) begin
                    rrd_cnt <= CNT_W'(1);
                end else if (rrd_cnt != '1) begin
                    rrd_cnt <= rrd_cnt + 1'b1;
                end
            end
        end
    end

    assign err = |viol;

    logic unused_running;
    assign unused_running = running;
endmodule

// File: rtl/sdtm_checker.sv
module sdtm_checker import sdtm_pkg::*; #(
    parameter int NBANK     = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RRD     = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cke,
    input logic                     cs_n,
    input logic                     ras_n,
    input logic                     cas_n,
    input logic                     we_n,
    input logic [$clog2(NBANK)-1:0] ba,
    input logic                     a10,
    input logic [NRULE-1:0]         viol,
    input logic                     err
);
    logic cke_d;
    logic act_v;
    logic col_v;

    always_ff @(posedge clk) begin
        if (rst) cke_d <= 1'b1;
        else     cke_d <= cke;
    end

    assign act_v = cke_d && !cs_n && !ras_n && cas_n && we_n;
    assign col_v = cke_d && !cs_n && ras_n && !cas_n;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (viol == '0 && !err)); // R1

    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cke_d |=> (viol == '0)); // R12

    AST_RASMAX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        viol[RL_RASMAX] |=> !viol[RL_RASMAX]); // R6

    if (T_RRD >= 2) begin : g_rrd
        AST_RRD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
            act_v ##1 act_v |=> viol[RL_RRD]); // R4
    end

    if (T_RCD >= 2) begin : g_rcd
        AST_RCD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
            act_v ##1 (col_v && ba == $past(ba)) |=> viol[RL_RCD]); // R2
    end

    if (BURST_LEN >= 2) begin : g_ap
        AST_AP_INTERRUPT: assert property (@(posedge clk) disable iff (rst)
            (col_v && a10) ##1 col_v |=> viol[RL_AP]); // R9
    end
endmodule

bind sdram_timing_mon sdtm_checker #(
    .NBANK     (NBANK),
    .BURST_LEN (BURST_LEN),
    .T_RCD     (T_RCD),
    .T_RRD     (T_RRD)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .a10   (a10),
    .viol  (viol),
    .err   (err)
);

// File: tb/tb_sdram_timing_mon.sv
module tb_sdram_timing_mon;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_BST = 3'b110;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_REF = 3'b001;
    localparam logic [2:0] C_MRS = 3'b000;
    localparam logic [2:0] C_NOP = 3'b111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [9:0] viol;
    logic       err;
    logic [9:0] seen;
    logic       seen_err;
    int         n_chk = 0;
    int         n_err = 0;

    always #5 clk = ~clk;

    sdram_timing_mon #(
        .NBANK(4), .BURST_LEN(4), .T_RCD(3), .T_RP(3), .T_RRD(2),
        .T_RAS_MIN(6), .T_RAS_MAX(40), .T_RDL(2)
    ) dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .viol(viol), .err(err)
    );

    task automatic issue(input logic [2:0] c, input int b, input bit ap);
        {ras_n, cas_n, we_n} = c;
        cs_n = 1'b0;
        ba   = 2'(b);
        a10  = ap;
        @(negedge clk);
        seen     = viol;
        seen_err = err;
        {ras_n, cas_n, we_n} = C_NOP;
        a10 = 1'b0;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0);
    endtask

    task automatic check(input string req, input logic [9:0] exp);
        n_chk++;
        if (seen !== exp || seen_err !== (|exp)) begin
            n_err++;
            $display("FAIL %s: viol=%b err=%b expected viol=%b err=%b",
                     req, seen, seen_err, exp, |exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cke = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        seen = viol; seen_err = err;
        check("R1 quiet after reset", '0);
        issue(C_RD, 0, 1'b0);
        check("R1/R10 banks idle after reset", 10'b1 << 8);
    endtask

    task automatic t_rcd();
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(1); issue(C_RD, 0, 1'b0);
        check("R2 read two cycles after activate", 10'b1 << 0);
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(2); issue(C_WR, 0, 1'b0);
        check("R2 write at exact tRCD", '0);
    endtask

    task automatic t_rrd();
        do_reset();
        issue(C_ACT, 0, 1'b0); issue(C_ACT, 1, 1'b0);
        check("R4 activates one cycle apart", 10'b1 << 2);
        nops(1); issue(C_ACT, 2, 1'b0);
        check("R4 activate at exact tRRD", '0);
    endtask

    task automatic t_ras_rp();
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(4); issue(C_PRE, 0, 1'b0);
        check("R5 precharge five cycles after activate", 10'b1 << 3);
        nops(1); issue(C_ACT, 0, 1'b0);
        check("R3 activate two cycles after precharge", 10'b1 << 1);
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(5); issue(C_PRE, 0, 1'b0);
        check("R5 precharge at exact tRAS min", '0);
        nops(2); issue(C_ACT, 0, 1'b0);
        check("R3 activate at exact tRP", '0);
    endtask

    task automatic t_rdl();
        do_reset();
        issue(C_ACT, 1, 1'b0); nops(2); issue(C_WR, 1, 1'b0); nops(3);
        issue(C_PRE, 1, 1'b0);
        check("R7 precharge one cycle after last write beat", 10'b1 << 5);
        do_reset();
        issue(C_ACT, 1, 1'b0); nops(2); issue(C_WR, 1, 1'b0); nops(4);
        issue(C_PRE, 1, 1'b0);
        check("R7 precharge at exact tRDL", '0);
        do_reset();
        issue(C_ACT, 1, 1'b0); nops(5); issue(C_WR, 1, 1'b0);
        issue(C_BST, 0, 1'b0);
        check("R13 burst stop legal", '0);
        issue(C_PRE, 1, 1'b0);
        check("R7 burst stop moves the last beat", '0);
    endtask

    task automatic t_dal();
        do_reset();
        issue(C_ACT, 2, 1'b0); nops(2); issue(C_WR, 2, 1'b1); nops(6);
        issue(C_ACT, 2, 1'b0);
        check("R8 activate four cycles after auto-precharge write", 10'b1 << 6);
        do_reset();
        issue(C_ACT, 2, 1'b0); nops(2); issue(C_WR, 2, 1'b1); nops(7);
        issue(C_ACT, 2, 1'b0);
        check("R8 activate at exact tRDL+tRP", '0);
    endtask

    task automatic t_rdap();
        do_reset();
        issue(C_ACT, 3, 1'b0); nops(2); issue(C_RD, 3, 1'b1); nops(4);
        issue(C_ACT, 3, 1'b0);
        check("R3 activate two cycles after read auto-precharge", 10'b1 << 1);
        do_reset();
        issue(C_ACT, 3, 1'b0); nops(2); issue(C_RD, 3, 1'b1); nops(5);
        issue(C_ACT, 3, 1'b0);
        check("R3 activate at tRP after read auto-precharge", '0);
        do_reset();
        issue(C_ACT, 3, 1'b0); nops(2); issue(C_RD, 3, 1'b1); nops(3);
        issue(C_RD, 3, 1'b0);
        check("R10 bank idle after auto-precharge", 10'b1 << 8);
    endtask

    task automatic t_ap();
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(1); issue(C_ACT, 1, 1'b0); nops(1);
        issue(C_RD, 0, 1'b1);
        check("R9 auto-precharge read legal", '0);
        issue(C_WR, 1, 1'b0);
        check("R9 access during auto-precharge burst", 10'b1 << 7);
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(1); issue(C_ACT, 1, 1'b0); nops(1);
        issue(C_RD, 0, 1'b1); nops(3); issue(C_WR, 1, 1'b0);
        check("R9 other bank after burst end", '0);
    endtask

    task automatic t_idle();
        do_reset();
        issue(C_REF, 0, 1'b0);
        check("R11 refresh with all idle", '0);
        issue(C_MRS, 0, 1'b0);
        check("R11 mode set with all idle", '0);
        issue(C_ACT, 1, 1'b0); nops(3); issue(C_REF, 0, 1'b0);
        check("R11 refresh with open bank", 10'b1 << 9);
        issue(C_MRS, 0, 1'b0);
        check("R11 mode set with open bank", 10'b1 << 9);
    endtask

    task automatic t_rasmax();
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(39);
        check("R6 no flag before tRAS max", '0);
        nops(1);
        check("R6 row open at tRAS max", 10'b1 << 4);
        nops(1);
        check("R6 flag is a single pulse", '0);
        do_reset();
        issue(C_ACT, 0, 1'b0); nops(39); issue(C_PRE, 0, 1'b0);
        check("R6 precharge at exact tRAS max", '0);
    endtask

    task automatic t_cke();
        do_reset();
        issue(C_ACT, 0, 1'b0);
        cke = 1'b0;
        nops(5);
        check("R12 stalled cycles quiet", '0);
        cke = 1'b1;
        issue(C_RD, 0, 1'b0);
        check("R12 command after stalled cycle ignored", '0);
        issue(C_RD, 0, 1'b0);
        check("R12 counters held during stall", 10'b1 << 0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_rcd();
        t_rrd();
        t_ras_rp();
        t_rdl();
        t_dal();
        t_rdap();
        t_ap();
        t_idle();
        t_rasmax();
        t_cke();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule